// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Router

This block collects a set of level-sensitive interrupt sources and hands each one to one or more of up to four processors. A source becomes eligible for a processor when its input is high, its global enable bit is on, the processor's bit in the source's routing word is on, and that processor has not masked it. Each processor has its own acknowledge register that names the lowest-numbered eligible source, a fixed code for a pending doorbell, or a fixed "nothing pending" code. A per-processor `irq_o` line is high whenever there is something to acknowledge.

Software uses two register windows on one synchronous bus. The shared window holds the control word, the enable set/clear registers and the routing words. The per-processor window, selected by `bus_cpu_i`, holds the mask set/clear registers and the acknowledge register. Enable and mask bits are changed by writing a source number, not a bitmap, so one write touches exactly one bit. Writes take effect at the clock edge that samples them. Reads return data one cycle later.

The read path is a two-state machine. `BUS_IDLE` moves to `BUS_RESP` when a read is sampled. `BUS_RESP` stays in `BUS_RESP` when another read arrives in the same cycle, and otherwise returns to `BUS_IDLE`. The response is valid exactly while the machine is in `BUS_RESP`.

Top module: `irq_hub_core`

## Requirements
- R1: After reset every enable bit is clear, every per-processor mask bit is set and every routing word is zero, so `irq_o` is all zero and each acknowledge read returns 1023 whatever the source inputs are.
- R2: A read of shared offset 0x00 returns NSRC in bits [11:2], with all other bits zero.
- R3: Writing source number n to shared offset 0x30 sets enable bit n, and writing it to shared offset 0x34 clears that bit. No other enable bit changes.
- R4: Writing n to per-processor offset 0x48 masks source n for the selected processor only. Writing n to per-processor offset 0x4C unmasks it.
- R5: The routing word of source n sits at shared offset 0x100 + 4·n. Bit c of bits [NCPU-1:0] allows processor c to take the source. The word reads back with all bits above NCPU-1 equal to zero.
- R6: A read of per-processor offset 0x44 returns, in bits [9:0], the lowest-numbered eligible source for that processor. A normal source takes precedence over a doorbell.
- R7: With no eligible source and no doorbell, the acknowledge value is 1023.
- R8: When `doorbell_i[c]` is high and processor c has no eligible source, its acknowledge value is 0.
- R9: Pending state follows the level inputs alone. Dropping a source input removes it without any write, and reading the acknowledge register changes nothing.
- R10: `irq_o[c]` is high exactly when processor c's acknowledge value is not 1023.
- R11: A source number of 0, or NSRC and above, written to an enable or mask set/clear register changes no state. Source 0 is never eligible.
- R12: `bus_rvalid_o` is high exactly in the cycle after each sampled read and carries data taken at that read's edge. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_win_i | input | 1 | 0 = shared window, 1 = per-processor window |
| bus_cpu_i | input | CPU_W | Processor whose per-processor window is addressed |
| bus_addr_i | input | ADDR_W | Byte offset inside the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid |
| bus_rdata_o | output | 32 | Read data |
| src_i | input | NSRC | Level source inputs; bit 0 is unused |
| doorbell_i | input | NCPU | Per-processor doorbell pending levels |
| irq_o | output | NCPU | Per-processor interrupt request |

## Verification
The bench targets the corner cases of priority and index handling. It makes two sources eligible at once; a priority encoder scanning from the wrong end would name the higher number. It writes the out-of-range number 40, whose low five bits equal a live source; a design that truncates before range-checking would enable that source and raise the acknowledge value. It shows one processor masking a source while another still takes it, and it shows a doorbell giving way to a real source; a shared mask or a reversed precedence would report the wrong processor's state or code 0. It also drops source inputs with no write and reads the acknowledge register twice; an acknowledge with side effects, or a latched pending bit, would leave a stale number behind.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    // Read-path states
    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    // Shared-window offsets
    localparam int OFF_CTRL     = 'h000;
    localparam int OFF_EN_SET   = 'h030;
    localparam int OFF_EN_CLR   = 'h034;
    localparam int OFF_ROUTE    = 'h100;

    // Per-processor window offsets
    localparam int OFF_ACK      = 'h044;
    localparam int OFF_MASK_SET = 'h048;
    localparam int OFF_MASK_CLR = 'h04C;

    // Acknowledge codes
    localparam logic [9:0] ACK_NONE     = 10'h3FF;
    localparam logic [9:0] ACK_DOORBELL = 10'h000;

endpackage

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int NCPU   = 4,
    parameter int ADDR_W = 13,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_req_i,
    input  logic                       win_i,
    input  logic [CPU_W-1:0]           cpu_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [31:0]                wdata_i,
    input  logic                       route_hit_i,
    input  logic [SRC_W-1:0]           route_idx_i,
    output logic [NSRC-1:0]            en_q,
    output logic [NSRC-1:0][NCPU-1:0]  route_q,
    output logic [NCPU-1:0][NSRC-1:0]  mask_q
);

    // A written source number is usable only when it names a real source
    logic             num_ok;
    logic [SRC_W-1:0] num_idx;
    logic             unused_wdata;

    assign num_ok       = (wdata_i[9:0] != 10'd0) && (wdata_i[9:0] < 10'(NSRC));
    assign num_idx      = wdata_i[SRC_W-1:0];
    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
            mask_q  <= '1;
        end else if (wr_req_i) begin
            if (!win_i) begin
                if (addr_i == ADDR_W'(OFF_EN_SET) && num_ok)
                    en_q[num_idx] <= 1'b1;
                if (addr_i == ADDR_W'(OFF_EN_CLR) && num_ok)
                    en_q[num_idx] <= 1'b0;
                if (route_hit_i)
                    route_q[route_idx_i] <= wdata_i[NCPU-1:0];
            end else begin
                if (addr_i == ADDR_W'(OFF_MASK_SET) && num_ok)
                    mask_q[cpu_i][num_idx] <= 1'b1;
                if (addr_i == ADDR_W'(OFF_MASK_CLR) && num_ok)
                    mask_q[cpu_i][num_idx] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_hub_pick.sv
module irq_hub_pick
    import irq_hub_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] elig_i,
    input  logic            doorbell_i,
    output logic [9:0]      ack_o,
    output logic            irq_o
);

    // Scan from the top down so the lowest eligible number is written last
    always_comb begin
        ack_o = doorbell_i ? ACK_DOORBELL : ACK_NONE;
        for (int n = NSRC - 1; n >= 0; n--) begin
            if (elig_i[n])
                ack_o = 10'(n);
        end
    end

    assign irq_o = (ack_o != ACK_NONE);

endmodule

// File: rtl/irq_hub_bus.sv
module irq_hub_bus
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int NCPU   = 4,
    parameter int ADDR_W = 13,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_req_i,
    input  logic                       win_i,
    input  logic [CPU_W-1:0]           cpu_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic                       route_hit_i,
    input  logic [SRC_W-1:0]           route_idx_i,
    input  logic [NSRC-1:0][NCPU-1:0]  route_q_i,
    input  logic [NCPU-1:0][9:0]       ack_i,
    output logic                       rvalid_o,
    output logic [31:0]                rdata_o
);

    bus_state_e  state_q, state_d;
    logic [31:0] rd_word;

    // Read data selection
    always_comb begin
        rd_word = '0;
        if (!win_i) begin
            if (addr_i == ADDR_W'(OFF_CTRL))
                rd_word[11:2] = 10'(NSRC);
            else if (route_hit_i)
                rd_word[NCPU-1:0] = route_q_i[route_idx_i];
        end else if (addr_i == ADDR_W'(OFF_ACK)) begin
            rd_word[9:0] = ack_i[cpu_i];
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req_i ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req_i ? BUS_RESP : BUS_IDLE;
        endcase
    end

    // State register and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_o <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req_i)
                rdata_o <= rd_word;
        end
    end

    // Outputs
    always_comb begin
        rvalid_o = (state_q == BUS_RESP);
    end

endmodule

// File: rtl/irq_hub_core.sv
module irq_hub_core
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int NCPU   = 4,
    parameter int ADDR_W = 13,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic              bus_win_i,
    input  logic [CPU_W-1:0]  bus_cpu_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic              bus_rvalid_o,
    output logic [31:0]       bus_rdata_o,
    input  logic [NSRC-1:0]   src_i,
    input  logic [NCPU-1:0]   doorbell_i,
    output logic [NCPU-1:0]   irq_o
);

    logic [NSRC-1:0]           en_q;
    logic [NSRC-1:0][NCPU-1:0] route_q;
    logic [NCPU-1:0][NSRC-1:0] mask_q;
    logic [NCPU-1:0][9:0]      ack_all;

    // Routing-word decode shared by the write and read paths
    logic [ADDR_W-1:0] route_off;
    logic              route_hit;
    logic [SRC_W-1:0]  route_idx;
    logic              unused_top;

    assign route_off  = bus_addr_i - ADDR_W'(OFF_ROUTE);
    assign route_hit  = (bus_addr_i >= ADDR_W'(OFF_ROUTE)) && (bus_addr_i[1:0] == 2'b00)
                        && (route_off[ADDR_W-1:2] < (ADDR_W-2)'(NSRC));
    assign route_idx  = route_off[SRC_W+1:2];
    assign unused_top = ^{route_off[1:0], src_i[0]};

    irq_hub_regs #(.NSRC(NSRC), .NCPU(NCPU), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req_i    (bus_req_i & bus_we_i),
        .win_i       (bus_win_i),
        .cpu_i       (bus_cpu_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .route_hit_i (route_hit),
        .route_idx_i (route_idx),
        .en_q        (en_q),
        .route_q     (route_q),
        .mask_q      (mask_q)
    );

    // One eligibility vector and one priority picker per processor
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NSRC-1:0] elig;
        for (genvar n = 0; n < NSRC; n++) begin : g_src
            if (n == 0) begin : g_zero
                assign elig[n] = 1'b0;
            end else begin : g_real
                assign elig[n] = src_i[n] & en_q[n] & route_q[n][c] & ~mask_q[c][n];
            end
        end
        irq_hub_pick #(.NSRC(NSRC)) u_pick (
            .elig_i     (elig),
            .doorbell_i (doorbell_i[c]),
            .ack_o      (ack_all[c]),
            .irq_o      (irq_o[c])
        );
    end

    irq_hub_bus #(.NSRC(NSRC), .NCPU(NCPU), .ADDR_W(ADDR_W)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req_i    (bus_req_i & ~bus_we_i),
        .win_i       (bus_win_i),
        .cpu_i       (bus_cpu_i),
        .addr_i      (bus_addr_i),
        .route_hit_i (route_hit),
        .route_idx_i (route_idx),
        .route_q_i   (route_q),
        .ack_i       (ack_all),
        .rvalid_o    (bus_rvalid_o),
        .rdata_o     (bus_rdata_o)
    );

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int NCPU   = 4,
    parameter int ADDR_W = 13
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_req_i,
    input logic                       bus_we_i,
    input logic                       bus_win_i,
    input logic [ADDR_W-1:0]          bus_addr_i,
    input logic [31:0]                bus_wdata_i,
    input logic                       bus_rvalid_o,
    input logic [31:0]                bus_rdata_o,
    input logic [NSRC-1:0]            src_i,
    input logic [NCPU-1:0]            doorbell_i,
    input logic [NCPU-1:0]            irq_o,
    input logic [NSRC-1:0]            en_q,
    input logic [NSRC-1:0][NCPU-1:0]  route_q,
    input logic [NCPU-1:0][NSRC-1:0]  mask_q
);

    logic unused_chk;
    assign unused_chk = ^{en_q, route_q, mask_q};

    // R12
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && !bus_we_i) |=> bus_rvalid_o);

    // R12
    no_extra_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req_i && !bus_we_i) |=> !bus_rvalid_o);

    // R2
    ctrl_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && !bus_we_i && !bus_win_i && bus_addr_i == ADDR_W'(OFF_CTRL))
        |=> (bus_rdata_o == (32'(NSRC) << 2)));

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && bus_we_i && !bus_win_i && bus_addr_i == ADDR_W'(OFF_EN_SET)
         && bus_wdata_i == 32'd1) |=> en_q[1]);

    // R6
    elig_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[1] && en_q[1] && route_q[1][0] && !mask_q[0][1]) |-> irq_o[0]);

    // R7
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0 && doorbell_i == '0) |-> (irq_o == '0));

    // R8
    doorbell_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell_i[0] |-> irq_o[0]);

endmodule

bind irq_hub_core irq_hub_chk #(.NSRC(NSRC), .NCPU(NCPU), .ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_i    (bus_req_i),
    .bus_we_i     (bus_we_i),
    .bus_win_i    (bus_win_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rvalid_o (bus_rvalid_o),
    .bus_rdata_o  (bus_rdata_o),
    .src_i        (src_i),
    .doorbell_i   (doorbell_i),
    .irq_o        (irq_o),
    .en_q         (en_q),
    .route_q      (route_q),
    .mask_q       (mask_q)
);

// File: tb/irq_hub_core_tb_top.sv
`timescale 1ns/1ps
module irq_hub_core_tb_top;

    localparam int NSRC   = 32;
    localparam int NCPU   = 4;
    localparam int ADDR_W = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic              bus_win = 1'b0;
    logic [1:0]        bus_cpu = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rvalid;
    logic [31:0]       bus_rdata;
    logic [NSRC-1:0]   src = '0;
    logic [NCPU-1:0]   db = '0;
    logic [NCPU-1:0]   irq;

    int checks = 0;
    int errors = 0;
    int reads_issued = 0;
    int reads_seen = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #2.5 clk = ~clk;

    irq_hub_core #(.NSRC(NSRC), .NCPU(NCPU), .ADDR_W(ADDR_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req_i    (bus_req),
        .bus_we_i     (bus_we),
        .bus_win_i    (bus_win),
        .bus_cpu_i    (bus_cpu),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rvalid_o (bus_rvalid),
        .bus_rdata_o  (bus_rdata),
        .src_i        (src),
        .doorbell_i   (db),
        .irq_o        (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit win, input int cpu, input int addr, input int data);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_win = win;
        bus_cpu = 2'(cpu); bus_addr = ADDR_W'(addr); bus_wdata = 32'(data);
        @(posedge clk);
        #1 bus_req = 1'b0;
    endtask

    // Driver: issues a read and pushes the expected response
    task automatic rd(input bit win, input int cpu, input int addr, input int exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_win = win;
        bus_cpu = 2'(cpu); bus_addr = ADDR_W'(addr);
        it.exp = 32'(exp); it.tag = tag;
        sb.push_back(it);
        reads_issued++;
        @(posedge clk);
        #1 bus_req = 1'b0;
    endtask

    task automatic chk_irq(input logic [NCPU-1:0] exp, input string tag);
        @(negedge clk);
        check(tag, 32'(irq), 32'(exp));
    endtask

    // Monitor: pops and compares whenever a response is presented
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            reads_seen++;
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 unexpected response actual=%0d expected=none", bus_rdata);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        chk_irq(4'b0000, "R1 irq after reset");
        src = '1;
        chk_irq(4'b0000, "R1 irq with all sources high");
        rd(1, 0, 'h44, 1023, "R1 ack after reset");
        rd(0, 0, 'h114, 0, "R1 route word after reset");
        src = '0;

        // R2 / R12
        rd(0, 0, 'h000, NSRC << 2, "R2 control count");
        rd(0, 0, 'h040, 0, "R12 unmapped read");

        // R5 / R3 / R4: source 5 to processor 0
        wr(0, 0, 'h114, 'hFFFF_FFF1);
        rd(0, 0, 'h114, 1, "R5 route readback");
        wr(0, 0, 'h30, 5);
        wr(1, 0, 'h4C, 5);
        src[5] = 1'b1;
        chk_irq(4'b0001, "R10 irq for source 5");
        rd(1, 0, 'h44, 5, "R6 ack source 5");
        rd(1, 1, 'h44, 1023, "R5 unrouted processor");

        // R9: no read side effects, level following
        rd(1, 0, 'h44, 5, "R9 repeated ack");
        src[5] = 1'b0;
        chk_irq(4'b0000, "R9 irq drops with input");
        rd(1, 0, 'h44, 1023, "R7 ack after drop");

        // R6 / R3: two sources, then clear the lower
        wr(0, 0, 'h11C, 3);
        wr(0, 0, 'h30, 7);
        wr(1, 0, 'h4C, 7);
        src[5] = 1'b1; src[7] = 1'b1;
        rd(1, 0, 'h44, 5, "R6 lowest wins");
        wr(0, 0, 'h34, 5);
        rd(1, 0, 'h44, 7, "R3 clear leaves other enable");

        // R4: per-processor masks
        rd(1, 1, 'h44, 1023, "R4 masked on processor 1");
        wr(1, 1, 'h4C, 7);
        rd(1, 1, 'h44, 7, "R4 unmasked on processor 1");
        wr(1, 0, 'h48, 7);
        rd(1, 0, 'h44, 1023, "R4 masked on processor 0");
        rd(1, 1, 'h44, 7, "R4 processor 1 unaffected");
        chk_irq(4'b0010, "R10 irq only processor 1");

        // R11: out-of-range numbers
        wr(0, 0, 'h34, 7);
        src[8] = 1'b1;
        wr(0, 0, 'h120, 2);
        wr(1, 1, 'h4C, 8);
        rd(1, 1, 'h44, 1023, "R11 source 8 not yet enabled");
        wr(0, 0, 'h30, 40);
        wr(0, 0, 'h30, 0);
        rd(1, 1, 'h44, 1023, "R11 number 40 ignored");
        wr(0, 0, 'h30, 8);
        rd(1, 1, 'h44, 8, "R3 enable source 8");
        wr(0, 0, 'h34, 40);
        rd(1, 1, 'h44, 8, "R11 clear of 40 ignored");

        // R8: doorbell
        db[2] = 1'b1;
        chk_irq(4'b0110, "R8 doorbell raises irq");
        rd(1, 2, 'h44, 0, "R8 doorbell code");
        wr(0, 0, 'h120, 6);
        wr(1, 2, 'h4C, 8);
        rd(1, 2, 'h44, 8, "R6 source beats doorbell");
        db[2] = 1'b0;

        // R6: lower source on processor 2
        wr(0, 0, 'h10C, 4);
        wr(0, 0, 'h30, 3);
        wr(1, 2, 'h4C, 3);
        src[3] = 1'b1;
        rd(1, 2, 'h44, 3, "R6 lower source wins on processor 2");
        rd(1, 1, 'h44, 8, "R5 processor 1 not routed to 3");

        src = '0;
        chk_irq(4'b0000, "R9 all inputs low");

        repeat (4) @(negedge clk);
        check("R12 responses matched", 32'(reads_seen), 32'(reads_issued));
        check("R12 scoreboard drained", 32'(sb.size()), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule